// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is one DMA channel that owns a source address, a remaining-transfer counter and a small control word. Once software enables it, the channel issues one bus cycle at a time. Each bus cycle carries the current source address and the transfer width. When the bus reports that the cycle is done, the channel moves the address by the width-dependent step and counts the transfer off. It either starts transfers back to back by itself or waits for one external request per transfer.

When the last transfer completes, the channel drops its own enable bit and, if asked to, emits a one-cycle interrupt pulse. The enable bit is guarded: a write of 1 only takes hold if software has first read the control word while the channel was off. A separate master enable must also be 1 before any transfer is issued. Destination handling, arbitration between channels and the data path itself sit outside this block.

Register map, selected by `reg_sel`:

- 0: source address.
- 1: transfer count.
- 2: control word, with bit 0 enable, bit 1 word size, bit 2 step enable, bit 3 step direction, bit 4 interrupt enable and bit 5 self-start.
- 3: master enable, in bit 0.

`rd_data` is a combinational view of the register that `reg_sel` selects. The other bits of `rd_data` read as zero.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the control word reads 0 (disabled, byte size, step mode {dir,step}=00, interrupt off, self-start off), the master enable reads 0, and `bus_req` and `irq` are 0.
- R2: No bus cycle is issued unless both the enable bit (control bit 0) and the master enable (register 3 bit 0) are 1; a request pulse arriving while the channel is not active is not remembered.
- R3: With self-start (control bit 5) set, an active channel issues its transfers with no `xfer_req` pulse. After each `bus_done` it raises `bus_req` again until the count is used up.
- R4: With self-start clear, each `xfer_req` pulse yields exactly one bus cycle. A pulse arriving while a bus cycle is outstanding is held and served after that cycle's `bus_done`.
- R5: While the enable bit is 0, `xfer_req` pulses are ignored: no bus cycle follows, not even after the channel is enabled again.
- R6: Only one bus cycle is outstanding: `bus_req` stays 1 with `bus_addr` stable until `bus_done` is seen, and the next cycle starts no earlier than one clock later.
- R7: The counter decrements once per completed cycle. On the completion that takes it from 1 to 0, the enable bit reads 0, the count reads 0 and no further bus cycle is issued.
- R8: On that terminal completion, `irq` is 1 for exactly one clock (the clock after `bus_done` is sampled) when the interrupt enable (control bit 4) is 1. `irq` stays 0 when that bit is 0 and at every other completion.
- R9: A write of 1 to the enable bit sets it only if the control word was read while the enable bit was 0, with no control write in between. Otherwise the enable bit stays 0.
- R10: After each completed cycle the source address changes by a step of 1 for byte size (control bit 1 = 0) or 2 for word size (bit 1 = 1). The step mode {dir,step} (bits 3,2) selects the change: 01 adds the step, 11 subtracts it, 00 and 10 leave the address unchanged.
- R11: The source address is 24 bits and wraps modulo 2^24 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of register 2 arms the enable) |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 24 | Write data |
| rd_data | output | 24 | Read data of the selected register |
| xfer_req | input | 1 | Transfer request pulse |
| bus_req | output | 1 | Bus cycle outstanding |
| bus_addr | output | 24 | Source address of the outstanding cycle |
| bus_word | output | 1 | 1 = word cycle, 0 = byte cycle |
| bus_done | input | 1 | Bus cycle completed |
| irq | output | 1 | Terminal-count interrupt pulse |

## Verification
The hardest situation to reach from the ports is a request pulse that lands while a bus cycle is still outstanding. That pulse must be held and served later, but only while the channel is active. The stimulus holds `bus_done` back and pulses `xfer_req` mid-cycle, then checks that a second cycle appears at the next address with no further pulse. It then pulses `xfer_req` with the channel disabled and re-enables it, expecting silence. A sweep over all four step modes, both sizes, both start modes and two base addresses straddling the 2^24 wrap checks every issued address and the terminal state against arithmetic expectations.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD_A = 2'b00,
    MODE_INC    = 2'b01,
    MODE_HOLD_B = 2'b10,
    MODE_DEC    = 2'b11
  } src_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } seq_state_e;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_CNT = 2'd1;
  localparam logic [1:0] SEL_CTL = 2'd2;
  localparam logic [1:0] SEL_MST = 2'd3;

  localparam int CTL_EN   = 0;
  localparam int CTL_WORD = 1;
  localparam int CTL_STEP = 2;
  localparam int CTL_DIR  = 3;
  localparam int CTL_IE   = 4;
  localparam int CTL_AUTO = 5;
  localparam int CTL_W    = 6;

  typedef struct packed {
    logic auto_req;
    logic int_en;
    logic dir;
    logic step_en;
    logic word;
  } ctl_t;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [1:0]        mode,
  input  logic              word,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [ADDR_W-1:0] step;

  always_comb begin
    step = word ? ADDR_W'(2) : ADDR_W'(1);
    case (src_mode_e'(mode))
      MODE_INC: nxt_addr = cur_addr + step;
      MODE_DEC: nxt_addr = cur_addr - step;
      default:  nxt_addr = cur_addr;
    endcase
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] rd_data,
  input  logic              xfer_fin,
  input  logic [ADDR_W-1:0] nxt_addr,
  output logic [ADDR_W-1:0] src_addr,
  output ctl_t              ctl,
  output logic              ch_en,
  output logic              ch_act,
  output logic              cnt_last,
  output logic              armed
);
  logic [ADDR_W-1:0] src_q, src_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  ctl_t              ctl_q, ctl_d;
  logic              en_q, en_d, men_q, men_d, arm_q, arm_d;
  logic              upd;

  assign upd      = reg_wr | reg_rd | xfer_fin;
  assign cnt_last = (cnt_q == CNT_W'(1));

  always_comb begin
    src_d = src_q;
    cnt_d = cnt_q;
    ctl_d = ctl_q;
    en_d  = en_q;
    men_d = men_q;
    arm_d = arm_q;
    if (reg_rd && reg_sel == SEL_CTL && !en_q) arm_d = 1'b1;
    if (reg_wr) begin
      case (reg_sel)
        SEL_SRC: src_d = reg_wdata;
        SEL_CNT: cnt_d = reg_wdata[CNT_W-1:0];
        SEL_CTL: begin
          ctl_d.auto_req = reg_wdata[CTL_AUTO];
          ctl_d.int_en   = reg_wdata[CTL_IE];
          ctl_d.dir      = reg_wdata[CTL_DIR];
          ctl_d.step_en  = reg_wdata[CTL_STEP];
          ctl_d.word     = reg_wdata[CTL_WORD];
          if (!reg_wdata[CTL_EN]) en_d = 1'b0;
          else if (arm_q)         en_d = 1'b1;
          arm_d = 1'b0;
        end
        default: men_d = reg_wdata[0];
      endcase
    end
    if (xfer_fin) begin
      src_d = nxt_addr;
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_last) en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      cnt_q <= '0;
      ctl_q <= '0;
      en_q  <= 1'b0;
      men_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (upd) begin
      src_q <= src_d;
      cnt_q <= cnt_d;
      ctl_q <= ctl_d;
      en_q  <= en_d;
      men_q <= men_d;
      arm_q <= arm_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_sel)
      SEL_SRC: rd_data = src_q;
      SEL_CNT: rd_data[CNT_W-1:0] = cnt_q;
      SEL_CTL: rd_data[CTL_W-1:0] = {ctl_q.auto_req, ctl_q.int_en, ctl_q.dir,
                                     ctl_q.step_en, ctl_q.word, en_q};
      default: rd_data[0] = men_q;
    endcase
  end

  assign src_addr = src_q;
  assign ctl      = ctl_q;
  assign ch_en    = en_q;
  assign ch_act   = en_q & men_q;
  assign armed    = arm_q;
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ch_act,
  input  logic auto_req,
  input  logic int_en,
  input  logic cnt_last,
  input  logic xfer_req,
  input  logic bus_done,
  output logic bus_req,
  output logic xfer_fin,
  output logic irq
);
  seq_state_e state_q, state_d;
  logic       pend_q, pend_d, irq_q, irq_d;
  logic       issue, tc_hit;

  assign issue    = (state_q == ST_IDLE) && ch_act && (auto_req || pend_q);
  assign xfer_fin = (state_q == ST_BUSY) && bus_done;
  assign tc_hit   = xfer_fin && cnt_last;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (issue)    state_d = ST_BUSY;
      default: if (bus_done) state_d = ST_IDLE;
    endcase
    pend_d = ch_act && !tc_hit && ((pend_q && !issue) || xfer_req);
    irq_d  = tc_hit && int_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      irq_q   <= irq_d;
    end
  end

  assign bus_req = (state_q == ST_BUSY);
  assign irq     = irq_q;
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] rd_data,
  input  logic              xfer_req,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_word,
  input  logic              bus_done,
  output logic              irq
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [ADDR_W-1:0] src_addr, nxt_addr;
  ctl_t              ctl;
  logic              ch_en, ch_act, cnt_last, armed, xfer_fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  dma_ctrl_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rd_data(rd_data),
    .xfer_fin(xfer_fin), .nxt_addr(nxt_addr), .src_addr(src_addr),
    .ctl(ctl), .ch_en(ch_en), .ch_act(ch_act), .cnt_last(cnt_last),
    .armed(armed)
  );

  dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr(src_addr), .mode({ctl.dir, ctl.step_en}), .word(ctl.word),
    .nxt_addr(nxt_addr)
  );

  dma_xfer_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .ch_act(ch_act), .auto_req(ctl.auto_req),
    .int_en(ctl.int_en), .cnt_last(cnt_last), .xfer_req(xfer_req),
    .bus_done(bus_done), .bus_req(bus_req), .xfer_fin(xfer_fin), .irq(irq)
  );

  assign bus_addr = src_addr;
  assign bus_word = ctl.word;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq,
  input logic              ch_act,
  input logic              ch_en,
  input logic              armed,
  input logic              step_en
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr)));  // R6
  AST_ISSUE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(ch_act));  // R2
  AST_IRQ_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!ch_en && $past(bus_done) && $past(bus_req)));  // R8
  AST_EN_SET_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_en) |-> $past(armed));  // R9
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done && !step_en) |=> $stable(bus_addr));  // R10
endmodule

bind dma_chan_seq dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_req(bus_req), .bus_done(bus_done),
  .bus_addr(bus_addr), .irq(irq), .ch_act(ch_act), .ch_en(ch_en),
  .armed(armed), .step_en(ctl.step_en)
);

// File: tb/sim_dma_chan_seq.sv
`timescale 1ns/1ps
module sim_dma_chan_seq;
  localparam int AW = 24;
  localparam real HALF = 4.0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] rd_data;
  logic          xfer_req = 1'b0, bus_done = 1'b0;
  logic          bus_req, bus_word, irq;
  logic [AW-1:0] bus_addr;

  int vectors = 0;
  int errors  = 0;
  bit done_flag = 1'b0;

  always #(HALF) clk = ~clk;

  dma_chan_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rd_data(rd_data),
    .xfer_req(xfer_req), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_word(bus_word), .bus_done(bus_done), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [AW-1:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel;
    #1 v = rd_data;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_req(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 20 && !seen; k++) begin
      if (bus_req) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  // bus_done sampled at the next posedge; leaves the bench at the negedge after
  task automatic finish_cycle();
    bus_done = 1'b1;
    @(negedge clk);
    bus_done = 1'b0;
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base,
      input logic [1:0] mode, input bit word, input int i);
    logic [AW-1:0] st;
    st = AW'((word ? 2 : 1) * i);
    case (mode)
      2'b01:   return base + st;
      2'b11:   return base - st;
      default: return base;
    endcase
  endfunction

  function automatic logic [AW-1:0] ctl_word(input bit au, input bit ie,
      input logic [1:0] mode, input bit word, input bit en);
    return AW'({au, ie, mode[1], mode[0], word, en});
  endfunction

  task automatic run_case(input logic [1:0] mode, input bit word, input bit au,
      input bit ie, input logic [AW-1:0] base);
    logic [AW-1:0] v, ea;
    bit seen;
    wr(2'd0, base);
    wr(2'd1, AW'(3));
    rd(2'd2, v);
    chk("R7 enable idle before case", 32'(v[0]), 32'd0);
    wr(2'd2, ctl_word(au, ie, mode, word, 1'b1));
    for (int i = 0; i < 3; i++) begin
      if (!au) pulse_req();
      wait_req(seen);
      chk(au ? "R3 self-start issue" : "R4 request issue", 32'(seen), 32'd1);
      ea = exp_addr(base, mode, word, i);
      chk((base > 24'h800000) ? "R11 R10 bus_addr" : "R10 bus_addr", 32'(bus_addr), 32'(ea));
      chk("R10 bus_word", 32'(bus_word), 32'(word));
      idle(i);
      chk("R6 request held", 32'(bus_req), 32'd1);
      chk("R6 address stable", 32'(bus_addr), 32'(ea));
      finish_cycle();
      chk("R8 irq", 32'(irq), (i == 2) ? 32'(ie) : 32'd0);
    end
    idle(4);
    chk("R7 no issue after terminal", 32'(bus_req), 32'd0);
    rd(2'd1, v);
    chk("R7 count zero", 32'(v), 32'd0);
    rd(2'd0, v);
    chk("R11 R10 final address", 32'(v), 32'(exp_addr(base, mode, word, 3)));
    rd(2'd2, v);
    chk("R7 enable cleared", 32'(v[0]), 32'd0);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] v;
    bit seen;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    rd(2'd2, v);
    chk("R1 control word", 32'(v), 32'd0);
    rd(2'd3, v);
    chk("R1 master enable", 32'(v), 32'd0);
    chk("R1 bus_req", 32'(bus_req), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);

    // handshake: the reset-time control read above armed; a write clears the arm
    wr(2'd2, ctl_word(1'b0, 1'b0, 2'b01, 1'b0, 1'b0));
    wr(2'd0, AW'(24'h000100));
    wr(2'd1, AW'(2));
    wr(2'd2, ctl_word(1'b0, 1'b0, 2'b01, 1'b0, 1'b1));
    rd(2'd2, v);
    chk("R9 write without read", 32'(v[0]), 32'd0);
    wr(2'd2, ctl_word(1'b0, 1'b0, 2'b01, 1'b0, 1'b1));
    rd(2'd2, v);
    chk("R9 write after read", 32'(v[0]), 32'd1);

    // master enable still 0
    pulse_req();
    idle(5);
    chk("R2 master off", 32'(bus_req), 32'd0);
    wr(2'd3, AW'(1));
    idle(5);
    chk("R2 request not kept", 32'(bus_req), 32'd0);

    // request held across an outstanding cycle
    pulse_req();
    wait_req(seen);
    chk("R4 first issue", 32'(seen), 32'd1);
    chk("R4 first address", 32'(bus_addr), 32'h000100);
    pulse_req();
    idle(2);
    finish_cycle();
    chk("R6 gap after done", 32'(bus_req), 32'd0);
    wait_req(seen);
    chk("R4 held request served", 32'(seen), 32'd1);
    chk("R4 second address", 32'(bus_addr), 32'h000101);
    finish_cycle();
    idle(4);
    rd(2'd2, v);
    chk("R7 terminal clear", 32'(v[0]), 32'd0);

    // disabled channel ignores requests
    pulse_req();
    idle(5);
    chk("R5 ignored while off", 32'(bus_req), 32'd0);
    wr(2'd1, AW'(1));
    rd(2'd2, v);
    wr(2'd2, ctl_word(1'b0, 1'b0, 2'b01, 1'b0, 1'b1));
    idle(5);
    chk("R5 nothing remembered", 32'(bus_req), 32'd0);
    pulse_req();
    wait_req(seen);
    chk("R5 live after enable", 32'(seen), 32'd1);
    chk("R5 address", 32'(bus_addr), 32'h000102);
    finish_cycle();
    idle(3);

    // sweep: step modes x sizes x start modes x bases near both wrap edges
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 2; w++)
        for (int a = 0; a < 2; a++)
          for (int b = 0; b < 2; b++)
            run_case(2'(m), bit'(w), bit'(a), bit'((m + w + b) % 2),
                     (b == 0) ? AW'(24'h000001) : AW'(24'hFFFFFE));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule